// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a small boot-block flash memory that sits behind an asynchronous parallel bus. Bus write strobes are recovered inside the clock domain. Command bytes, together with their address and data, are taken at the rising edge of the write strobe. One-byte commands set what a read returns: array contents, a status byte or identification codes. Two-byte sequences start a byte program or a block erase. A running erase can be paused and resumed.

The storage is a parameterised bank of byte registers. Erased bytes read as FFH. Each block covers a power-of-two range of addresses. Program and erase last for parameterised counts of clock cycles. All bus commands are gated by a programming-voltage-valid input. A power-down input takes the block back to its reset state and floats the data bus. High impedance is modelled by a drive-enable output, and the data bus reads zero while that enable is low.

Top module: `flash_cmd_if`

## Requirements
- R1: A write is taken at the clock after write enable rises while chip enable is low. The command, address and data are the values present at that rise. Values present only earlier in the low phase are discarded.
- R2: While vppOk is low, writes change neither the read mode nor any other state.
- R3: After reset, and after command FFH at any address, reads return the array. The array resets to FFH in every byte.
- R4: Command 40H or 10H followed by a write of address and data programs that byte. Reads then return status with bit 7 (ready) at 0 for PROG_CYC cycles. After that, ready returns to 1 and the byte holds the data.
- R5: Command 70H makes reads at any address return the status byte: {ready, erase-suspended, erase-error, 5'b0}.
- R6: Command 50H clears the erase-error bit (status bit 5).
- R7: Command 20H at an address, then D0H at an address in the same block, erases the block. Block = address bits above BLK_W. After ERASE_CYC cycles every byte of that block reads FFH, and other blocks are unchanged.
- R8: An erase setup followed by any byte other than D0H, or by D0H in another block, erases nothing. It sets status bit 5 and leaves reads in status mode.
- R9: During an erase, B0H suspends it: status reads C0H and the countdown holds, and FFH, 70H and 90H stay usable. D0H resumes the erase, which then completes.
- R10: Command 90H makes a read at address 0 return 31H. A read at address 1 returns 7CH when TOP_BOOT=1 and 7DH when TOP_BOOT=0.
- R11: dataDrive is high only when rpN=1, ceN=0, oeN=0 and weN=1. dataOut is 00H whenever dataDrive is low.
- R12: Holding rpN low aborts any operation, clears the error bit, restores array read and ignores writes.
- R13: While a program or an unsuspended erase runs, every write except B0H (erase only) is ignored, and reads return status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous-style chip reset, active low, sampled synchronously |
| rpN | input | 1 | Power-down, active low |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low; commands taken on its rise |
| vppOk | input | 1 | Programming voltage valid |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Write data / command byte |
| dataOut | output | 8 | Read data, 00H when not driven |
| dataDrive | output | 1 | High when the bus would be driven |

## Verification
The bench builds the block with 64 bytes in four 16-byte blocks, PROG_CYC=6 and ERASE_CYC=12. With these values the busy window of a program is long enough to issue one more full write and a status read before ready returns, and an erase is long enough to be suspended partway through. A second copy with TOP_BOOT=0 receives the same bus traffic, so both device codes are checked from one command stream. Four blocks give a block in use, a neighbouring block that must survive an erase, and a third block for the wrong-block confirm.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2
  } read_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PSET  = 3'd1,
    ST_ESET  = 3'd2,
    ST_PBUSY = 3'd3,
    ST_EBUSY = 3'd4,
    ST_ESUSP = 3'd5
  } cmd_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;     // capture address/data of the operation
    logic commitProg;  // write latched byte into the array
    logic commitErase; // fill latched block with FFH
    logic setErr;      // flag a failed erase confirm
    logic clrErr;      // clear the erase-error flag
  } dp_strb_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_SIG        = 8'h90;

  localparam logic [7:0] MFG_CODE       = 8'h31;
  localparam logic [7:0] DEV_CODE_TOP   = 8'h7C;
  localparam logic [7:0] DEV_CODE_BOT   = 8'h7D;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rpN,
  input  logic                    ceN,
  input  logic                    weN,
  input  logic                    vppOk,
  input  logic [ADDR_W-BLK_W-1:0] blkAddr,
  input  logic [7:0]              dataIn,
  output read_mode_t              readMode,
  output dp_strb_t                strb,
  output logic                    ready,
  output logic                    suspended
);

  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  cmd_state_t              st;
  logic                    weQ;
  logic                    wrStb;
  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-BLK_W-1:0] setupBlk;
  logic                    confirmOk;
  logic                    suspendReq;
  logic                    cntZero;

  assign wrStb      = rpN && vppOk && !ceN && !weQ && weN;
  assign confirmOk  = (dataIn == CMD_CONFIRM) && (blkAddr == setupBlk);
  assign suspendReq = wrStb && (dataIn == CMD_SUSPEND);
  assign cntZero    = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ <= 1'b1;
    end else begin
      weQ <= rpN ? weN : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      readMode <= RM_ARRAY;
      cnt      <= '0;
      setupBlk <= '0;
    end else if (!rpN) begin
      st       <= ST_IDLE;
      readMode <= RM_ARRAY;
    end else begin
      unique case (st)
        ST_IDLE: if (wrStb) begin
          unique case (dataIn)
            CMD_READ_ARRAY: readMode <= RM_ARRAY;
            CMD_STATUS:     readMode <= RM_STATUS;
            CMD_SIG:        readMode <= RM_SIG;
            CMD_PROG_A,
            CMD_PROG_B:     st <= ST_PSET;
            CMD_ERASE: begin
              st       <= ST_ESET;
              setupBlk <= blkAddr;
              readMode <= RM_STATUS;
            end
            default: ;
          endcase
        end
        ST_PSET: if (wrStb) begin
          st       <= ST_PBUSY;
          cnt      <= PROG_LOAD;
          readMode <= RM_STATUS;
        end
        ST_ESET: if (wrStb) begin
          readMode <= RM_STATUS;
          if (confirmOk) begin
            st  <= ST_EBUSY;
            cnt <= ERASE_LOAD;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_PBUSY: begin
          if (cntZero) st <= ST_IDLE;
          else         cnt <= cnt - 1'b1;
        end
        ST_EBUSY: begin
          if (suspendReq)   st <= ST_ESUSP;
          else if (cntZero) st <= ST_IDLE;
          else              cnt <= cnt - 1'b1;
        end
        ST_ESUSP: if (wrStb) begin
          unique case (dataIn)
            CMD_CONFIRM: begin
              st       <= ST_EBUSY;
              readMode <= RM_STATUS;
            end
            CMD_READ_ARRAY: readMode <= RM_ARRAY;
            CMD_STATUS:     readMode <= RM_STATUS;
            CMD_SIG:        readMode <= RM_SIG;
            default: ;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb             = '0;
    strb.latchOp     = wrStb && (((st == ST_IDLE) && (dataIn == CMD_ERASE)) ||
                                 (st == ST_PSET));
    strb.commitProg  = rpN && (st == ST_PBUSY) && cntZero;
    strb.commitErase = rpN && (st == ST_EBUSY) && cntZero && !suspendReq;
    strb.setErr      = wrStb && (st == ST_ESET) && !confirmOk;
    strb.clrErr      = !rpN || (wrStb && (st == ST_IDLE) && (dataIn == CMD_CLR_STATUS));
  end

  assign ready     = (st != ST_PBUSY) && (st != ST_EBUSY);
  assign suspended = (st == ST_ESUSP);

  // R2: a write without valid programming voltage leaves the read mode alone
  a_r2_vpp_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!vppOk && rpN) |=> $stable(readMode));

  // R9: a suspended erase keeps its remaining count
  a_r9_susp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ESUSP) |=> (cnt == $past(cnt)));

  // R12: power-down returns to idle array read
  a_r12_powerdown: assert property (@(posedge clk) disable iff (!rstN)
    !rpN |=> ((st == ST_IDLE) && (readMode == RM_ARRAY)));

endmodule

// File: rtl/flash_cmd_data.sv
module flash_cmd_data
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BLK_W    = 4,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  dp_strb_t          strb,
  input  read_mode_t        readMode,
  input  logic              ready,
  input  logic              suspended,
  output logic [7:0]        dataOut,
  output logic              dataDrive
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_CODE_TOP : DEV_CODE_BOT;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        opData;
  logic              errBit;
  logic [DEPTH-1:0]  progHit;
  logic [DEPTH-1:0]  eraseHit;
  logic [7:0]        statusByte;
  logic [7:0]        sigByte;
  logic [7:0]        rdByte;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    assign progHit[g]  = strb.commitProg && (opAddr == IDX);
    assign eraseHit[g] = strb.commitErase &&
                         (opAddr[ADDR_W-1:BLK_W] == IDX[ADDR_W-1:BLK_W]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN)            mem[i] <= 8'hFF;
      else if (progHit[i])  mem[i] <= opData;
      else if (eraseHit[i]) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
      errBit <= 1'b0;
    end else begin
      if (strb.latchOp) begin
        opAddr <= addr;
        opData <= dataIn;
      end
      if (strb.setErr)      errBit <= 1'b1;
      else if (strb.clrErr) errBit <= 1'b0;
    end
  end

  assign statusByte = {ready, suspended, errBit, 5'b0};

  always_comb begin
    if (addr == ADDR_W'(0))      sigByte = MFG_CODE;
    else if (addr == ADDR_W'(1)) sigByte = DEV_CODE;
    else                         sigByte = 8'h00;
  end

  always_comb begin
    unique case (readMode)
      RM_STATUS: rdByte = statusByte;
      RM_SIG:    rdByte = sigByte;
      default:   rdByte = mem[addr];
    endcase
  end

  assign dataDrive = rpN && !ceN && !oeN && weN;
  assign dataOut   = dataDrive ? rdByte : 8'h00;

  // R4: a committed program lands at the latched address
  a_r4_prog_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitProg |=> (mem[$past(opAddr)] == $past(opData)));

  // R7: a committed erase leaves the block base at FFH
  a_r7_erase_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitErase |=>
      (mem[{$past(opAddr[ADDR_W-1:BLK_W]), {BLK_W{1'b0}}}] == 8'hFF));

  // R8: a failed confirm raises the error flag
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> errBit);

  // R6: a clear request drops the error flag
  a_r6_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrErr && !strb.setErr) |=> !errBit);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  parameter bit TOP_BOOT  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rpN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              vppOk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataDrive
);

  dp_strb_t   strb;
  read_mode_t readMode;
  logic       ready;
  logic       suspended;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .weN(weN), .vppOk(vppOk),
    .blkAddr(addr[ADDR_W-1:BLK_W]), .dataIn(dataIn),
    .readMode(readMode), .strb(strb), .ready(ready), .suspended(suspended)
  );

  flash_cmd_data #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .TOP_BOOT(TOP_BOOT)
  ) u_data (
    .clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .strb(strb), .readMode(readMode),
    .ready(ready), .suspended(suspended),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;

  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rpN = 1'b1, ceN = 1'b1, oeN = 1'b1, weN = 1'b1, vppOk = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, dataOutBot;
  logic dataDrive, dataDriveBot;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  flash_cmd_if #(.ADDR_W(ADDR_W), .BLK_W(4), .PROG_CYC(6), .ERASE_CYC(12), .TOP_BOOT(1'b1))
    u_flash_cmd_if (.clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN),
      .vppOk(vppOk), .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive));

  flash_cmd_if #(.ADDR_W(ADDR_W), .BLK_W(4), .PROG_CYC(6), .ERASE_CYC(12), .TOP_BOOT(1'b0))
    u_flash_cmd_if_bot (.clk(clk), .rstN(rstN), .rpN(rpN), .ceN(ceN), .oeN(oeN), .weN(weN),
      .vppOk(vppOk), .addr(addr), .dataIn(dataIn), .dataOut(dataOutBot), .dataDrive(dataDriveBot));

  localparam logic [1:0] OW = 2'd0, OR = 2'd1, OD = 2'd2, OV = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t TBL [NV] = '{
    '{OW, 8'h00, 8'h90, 8'h00, 4'd10},  // R10 signature mode
    '{OR, 8'h00, 8'h00, 8'h31, 4'd10},
    '{OR, 8'h01, 8'h00, 8'h7C, 4'd10},
    '{OW, 8'h05, 8'hFF, 8'h00, 4'd3},   // R3 back to array
    '{OR, 8'h05, 8'h00, 8'hFF, 4'd3},
    '{OW, 8'h03, 8'h40, 8'h00, 4'd4},   // R4 program with 40H
    '{OW, 8'h03, 8'hA5, 8'h00, 4'd4},
    '{OR, 8'h09, 8'h00, 8'h00, 4'd4},
    '{OD, 8'h00, 8'd10, 8'h00, 4'd4},
    '{OR, 8'h09, 8'h00, 8'h80, 4'd4},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd4},
    '{OR, 8'h03, 8'h00, 8'hA5, 4'd4},
    '{OW, 8'h00, 8'h70, 8'h00, 4'd5},   // R5 status at any address
    '{OR, 8'h33, 8'h00, 8'h80, 4'd5},
    '{OW, 8'h00, 8'h10, 8'h00, 4'd4},   // R4 program with 10H
    '{OW, 8'h14, 8'h55, 8'h00, 4'd4},
    '{OD, 8'h00, 8'd10, 8'h00, 4'd4},
    '{OW, 8'h10, 8'h20, 8'h00, 4'd7},   // R7 erase block 1
    '{OW, 8'h12, 8'hD0, 8'h00, 4'd7},
    '{OR, 8'h00, 8'h00, 8'h00, 4'd7},
    '{OD, 8'h00, 8'd20, 8'h00, 4'd7},
    '{OR, 8'h00, 8'h00, 8'h80, 4'd7},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd7},
    '{OR, 8'h14, 8'h00, 8'hFF, 4'd7},
    '{OR, 8'h03, 8'h00, 8'hA5, 4'd7},
    '{OW, 8'h00, 8'h40, 8'h00, 4'd8},   // R8 setup data in block 2
    '{OW, 8'h21, 8'h77, 8'h00, 4'd8},
    '{OD, 8'h00, 8'd10, 8'h00, 4'd8},
    '{OW, 8'h20, 8'h20, 8'h00, 4'd8},   // R8 wrong confirm byte
    '{OW, 8'h20, 8'hFF, 8'h00, 4'd8},
    '{OR, 8'h00, 8'h00, 8'hA0, 4'd8},
    '{OW, 8'h00, 8'h50, 8'h00, 4'd6},   // R6 clear error
    '{OR, 8'h00, 8'h00, 8'h80, 4'd6},
    '{OW, 8'h20, 8'h20, 8'h00, 4'd8},   // R8 confirm in other block
    '{OW, 8'h30, 8'hD0, 8'h00, 4'd8},
    '{OR, 8'h00, 8'h00, 8'hA0, 4'd8},
    '{OW, 8'h00, 8'h50, 8'h00, 4'd6},
    '{OR, 8'h00, 8'h00, 8'h80, 4'd6},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd8},
    '{OR, 8'h21, 8'h00, 8'h77, 4'd8},
    '{OW, 8'h21, 8'h20, 8'h00, 4'd9},   // R9 erase, suspend, resume
    '{OW, 8'h21, 8'hD0, 8'h00, 4'd9},
    '{OW, 8'h00, 8'hB0, 8'h00, 4'd9},
    '{OR, 8'h00, 8'h00, 8'hC0, 4'd9},
    '{OD, 8'h00, 8'd30, 8'h00, 4'd9},
    '{OR, 8'h00, 8'h00, 8'hC0, 4'd9},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd9},
    '{OR, 8'h21, 8'h00, 8'h77, 4'd9},
    '{OW, 8'h00, 8'hD0, 8'h00, 4'd9},
    '{OR, 8'h00, 8'h00, 8'h00, 4'd9},
    '{OD, 8'h00, 8'd20, 8'h00, 4'd9},
    '{OR, 8'h00, 8'h00, 8'h80, 4'd9},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd9},
    '{OR, 8'h21, 8'h00, 8'hFF, 4'd9},
    '{OW, 8'h00, 8'h40, 8'h00, 4'd13},  // R13 write ignored while busy
    '{OW, 8'h08, 8'h11, 8'h00, 4'd13},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd13},
    '{OR, 8'h00, 8'h00, 8'h00, 4'd13},
    '{OD, 8'h00, 8'd10, 8'h00, 4'd13},
    '{OR, 8'h00, 8'h00, 8'h80, 4'd13},
    '{OW, 8'h00, 8'hFF, 8'h00, 4'd13},
    '{OR, 8'h08, 8'h00, 8'h11, 4'd13},
    '{OV, 8'h00, 8'h90, 8'h00, 4'd2},   // R2 write with vppOk low
    '{OR, 8'h00, 8'h00, 8'hFF, 4'd2}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [7:0] d,
                         output logic [7:0] dBot);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    #2;
    d = dataOut; dBot = dataOutBot;
    #2;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd, rdBot;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 not driven while output enable high; R3 reset state reads array FFH
    check(11, {7'd0, dataDrive}, 8'h00);
    busRead(6'h00, rd, rdBot);
    check(3, rd, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      unique case (TBL[i].op)
        OW: busWrite(TBL[i].adr[ADDR_W-1:0], TBL[i].dat);
        OV: begin
          vppOk = 1'b0;
          busWrite(TBL[i].adr[ADDR_W-1:0], TBL[i].dat);
          vppOk = 1'b1;
        end
        OD: repeat (int'(TBL[i].dat)) @(negedge clk);
        default: begin
          busRead(TBL[i].adr[ADDR_W-1:0], rd, rdBot);
          check(int'(TBL[i].req), rd, TBL[i].exp);
          if (TBL[i].req == 4'd10 && TBL[i].adr == 8'h01)
            check(10, rdBot, 8'h7D);  // R10 bottom-boot code
        end
      endcase
    end

    // R1: only the value present at the rise of write enable counts
    @(negedge clk);
    addr = 6'h00; dataIn = 8'h70; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    dataIn = 8'h90;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    busRead(6'h00, rd, rdBot);
    check(1, rd, 8'h31);
    busWrite(6'h00, 8'hFF);

    // R11: output gating
    @(negedge clk);
    addr = 6'h00; ceN = 1'b0; oeN = 1'b1; #2;
    check(11, {dataDrive, dataOut[6:0]}, 8'h00);
    ceN = 1'b1; oeN = 1'b0; #2;
    check(11, {dataDrive, dataOut[6:0]}, 8'h00);
    ceN = 1'b0; rpN = 1'b0; #2;
    check(11, {dataDrive, dataOut[6:0]}, 8'h00);
    rpN = 1'b1; weN = 1'b0; #2;
    check(11, {dataDrive, dataOut[6:0]}, 8'h00);
    ceN = 1'b1; oeN = 1'b1; #2;
    weN = 1'b1;

    // R12: power-down aborts a program, clears error, ignores writes
    busWrite(6'h20, 8'h20);
    busWrite(6'h20, 8'hFF);
    busWrite(6'h00, 8'h40);
    busWrite(6'h09, 8'h22);
    @(negedge clk);
    rpN = 1'b0;
    busWrite(6'h00, 8'h90);
    @(negedge clk);
    rpN = 1'b1;
    busRead(6'h09, rd, rdBot);
    check(12, rd, 8'hFF);
    busRead(6'h00, rd, rdBot);
    check(12, rd, 8'hFF);
    busWrite(6'h00, 8'h70);
    busRead(6'h00, rd, rdBot);
    check(12, rd, 8'h80);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule